// File: doc/BRIEF.md
# Cycle-Holding Two-Master Bus Arbiter

This block lets two bus masters share a single downstream master port. Each upstream master drives a cycle flag (`cyc`), a transfer strobe (`stb`), write enable, address, write data and byte selects. In return it receives an acknowledge, a stall and read data. The arbiter picks one owner and passes that owner's request fields to the downstream port. The downstream acknowledge, stall and read data go back to the owner only.

Ownership is decided from the cycle flags, not from the strobes. A master keeps the bus for as long as it holds `cyc` high, so a burst of strobed transfers inside one cycle is never split. The grant is registered. A master that raises `cyc` on an idle bus owns it from the next clock. A master that is waiting takes over on the first edge where the owner's `cyc` is low.

Each master port works as a valid/ready stream. `stb` is the valid and `!stall` is the ready. A transfer is accepted on a clock where `stb` is high and `stall` is low. A master that does not own the bus sees `stall` held high, so none of its strobes can be accepted. Reset is synchronous and active high.

Top module: `cyc_hold_arbiter`

## Requirements
- R1: When no master owns the bus and exactly one master has `cyc` high at a rising edge, that master owns the bus from the next clock. In the clock where it first raises `cyc`, it still sees `stall` high.
- R2: When no master owns the bus, or the owner releases, and both masters have `cyc` high at the same edge, the grant goes to the master that did not win the previous grant. The first such tie after reset goes to master 0.
- R3: While the owner keeps `cyc` high, it keeps the bus, whatever the other master does.
- R4: Ownership ends at the first rising edge where the owner's `cyc` is low. Arbitration happens on that same edge, so a waiting master owns the bus from the next clock.
- R5: A master that does not own the bus sees `stall`=1, `ack`=0 and read data of all zeros.
- R6: The downstream port carries only the owner's fields. `s_cyc` equals the owner's `cyc`, and `s_stb` equals the owner's `stb` AND the owner's `cyc`. `s_we`, `s_adr`, `s_dat_w` and `s_sel` equal the owner's values. When no master owns the bus, every downstream request output is zero. A non-owner's strobe never reaches `s_stb`.
- R7: The owner sees `s_ack`, `s_stall` and `s_dat_r` unchanged, in the same clock they arrive.
- R8: While `rst` is high, no master owns the bus. All downstream request outputs are zero, and both masters see `stall`=1 and `ack`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| m0_cyc | input | 1 | Master 0 cycle flag |
| m0_stb | input | 1 | Master 0 transfer strobe (valid) |
| m0_we | input | 1 | Master 0 write enable |
| m0_adr | input | AW | Master 0 address |
| m0_dat_w | input | DW | Master 0 write data |
| m0_sel | input | DW/8 | Master 0 byte selects |
| m0_ack | output | 1 | Acknowledge to master 0 |
| m0_stall | output | 1 | Stall to master 0 (inverse ready) |
| m0_dat_r | output | DW | Read data to master 0 |
| m1_cyc | input | 1 | Master 1 cycle flag |
| m1_stb | input | 1 | Master 1 transfer strobe (valid) |
| m1_we | input | 1 | Master 1 write enable |
| m1_adr | input | AW | Master 1 address |
| m1_dat_w | input | DW | Master 1 write data |
| m1_sel | input | DW/8 | Master 1 byte selects |
| m1_ack | output | 1 | Acknowledge to master 1 |
| m1_stall | output | 1 | Stall to master 1 (inverse ready) |
| m1_dat_r | output | DW | Read data to master 1 |
| s_cyc | output | 1 | Downstream cycle flag |
| s_stb | output | 1 | Downstream strobe |
| s_we | output | 1 | Downstream write enable |
| s_adr | output | AW | Downstream address |
| s_dat_w | output | DW | Downstream write data |
| s_sel | output | DW/8 | Downstream byte selects |
| s_ack | input | 1 | Downstream acknowledge |
| s_stall | input | 1 | Downstream stall |
| s_dat_r | input | DW | Downstream read data |

## Verification
The bench targets these corner cases:

- **Simultaneous requests.** Both masters raise `cyc` in the same clock on an idle bus, and this happens several times in a row. A design without the alternation rule would favour one master every time. A design with a wrong reset value would hand the first tie to master 1.
- **Hold under pressure.** The owner keeps `cyc` high while the other master requests. A design that arbitrates on strobes would hand the bus over in the middle of a burst.
- **One-clock release.** The owner drops `cyc` for a single clock while the other master waits. A design that re-arbitrates a clock late would show a dead cycle. A design that re-arbitrates early would cut the final transfer.

A long pseudo-random sweep drives all cycle, strobe, field and response inputs. Every output is compared each clock against an arithmetic model. This exposes leaked strobes, acknowledges reaching the wrong master, and stale read data.

// File: rtl/arb_pkg.sv
package arb_pkg;
  localparam int NUM_M = 2;

  typedef struct packed {
    logic valid;
    logic id;
  } grant_t;
endpackage

// File: rtl/arb_grant_core.sv
module arb_grant_core
  import arb_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [NUM_M-1:0] req,
  output grant_t           grant
);
  grant_t cur_q, nxt;
  logic   last_q;
  logic   hold;

  assign hold = cur_q.valid && req[cur_q.id];

  always_comb begin
    nxt = cur_q;
    if (!hold) begin
      if (&req)        nxt = '{valid: 1'b1, id: ~last_q};
      else if (req[0]) nxt = '{valid: 1'b1, id: 1'b0};
      else if (req[1]) nxt = '{valid: 1'b1, id: 1'b1};
      else             nxt = '{valid: 1'b0, id: 1'b0};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_q  <= '{valid: 1'b0, id: 1'b0};
      last_q <= 1'b1;
    end else begin
      cur_q <= nxt;
      if (nxt.valid && !hold) last_q <= nxt.id;
    end
  end

  assign grant = cur_q;

  AST_GRANT_HELD: assert property (@(posedge clk) disable iff (rst)
    (cur_q.valid && req[cur_q.id]) |=> (cur_q.valid && cur_q.id == $past(cur_q.id))); // R3
  AST_HANDOVER: assert property (@(posedge clk) disable iff (rst)
    (cur_q.valid && !req[cur_q.id] && req[~cur_q.id]) |=> (cur_q.valid && cur_q.id != $past(cur_q.id))); // R4
  AST_FREE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    (!cur_q.valid && req == 2'b01) |=> (cur_q.valid && cur_q.id == 1'b0)); // R1
  AST_TIE_ALTERNATES: assert property (@(posedge clk) disable iff (rst)
    (!cur_q.valid && &req) |=> (cur_q.valid && cur_q.id == ~$past(last_q))); // R2
endmodule

// File: rtl/arb_req_mux.sv
module arb_req_mux
  import arb_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int SW = DW / 8
) (
  input  grant_t                     grant,
  input  logic [NUM_M-1:0]           cyc,
  input  logic [NUM_M-1:0]           stb,
  input  logic [NUM_M-1:0]           we,
  input  logic [NUM_M-1:0][AW-1:0]   adr,
  input  logic [NUM_M-1:0][DW-1:0]   dat_w,
  input  logic [NUM_M-1:0][SW-1:0]   sel,
  output logic                       o_cyc,
  output logic                       o_stb,
  output logic                       o_we,
  output logic [AW-1:0]              o_adr,
  output logic [DW-1:0]              o_dat_w,
  output logic [SW-1:0]              o_sel
);
  always_comb begin
    o_cyc   = 1'b0;
    o_stb   = 1'b0;
    o_we    = 1'b0;
    o_adr   = '0;
    o_dat_w = '0;
    o_sel   = '0;
    for (int i = 0; i < NUM_M; i++) begin
      if (grant.valid && grant.id == 1'(i)) begin
        o_cyc   = cyc[i];
        o_stb   = cyc[i] & stb[i];
        o_we    = we[i];
        o_adr   = adr[i];
        o_dat_w = dat_w[i];
        o_sel   = sel[i];
      end
    end
  end
endmodule

// File: rtl/arb_resp_route.sv
module arb_resp_route
  import arb_pkg::*;
#(
  parameter int DW = 32
) (
  input  grant_t                   grant,
  input  logic                     i_ack,
  input  logic                     i_stall,
  input  logic [DW-1:0]            i_dat_r,
  output logic [NUM_M-1:0]         ack,
  output logic [NUM_M-1:0]         stall,
  output logic [NUM_M-1:0][DW-1:0] dat_r
);
  for (genvar g = 0; g < NUM_M; g++) begin : g_port
    logic owns;
    assign owns     = grant.valid && grant.id == 1'(g);
    assign ack[g]   = owns ? i_ack : 1'b0;
    assign stall[g] = owns ? i_stall : 1'b1;
    assign dat_r[g] = owns ? i_dat_r : '0;
  end
endmodule

// File: rtl/cyc_hold_arbiter.sv
module cyc_hold_arbiter
  import arb_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  localparam int SW = DW / 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          m0_cyc,
  input  logic          m0_stb,
  input  logic          m0_we,
  input  logic [AW-1:0] m0_adr,
  input  logic [DW-1:0] m0_dat_w,
  input  logic [SW-1:0] m0_sel,
  output logic          m0_ack,
  output logic          m0_stall,
  output logic [DW-1:0] m0_dat_r,
  input  logic          m1_cyc,
  input  logic          m1_stb,
  input  logic          m1_we,
  input  logic [AW-1:0] m1_adr,
  input  logic [DW-1:0] m1_dat_w,
  input  logic [SW-1:0] m1_sel,
  output logic          m1_ack,
  output logic          m1_stall,
  output logic [DW-1:0] m1_dat_r,
  output logic          s_cyc,
  output logic          s_stb,
  output logic          s_we,
  output logic [AW-1:0] s_adr,
  output logic [DW-1:0] s_dat_w,
  output logic [SW-1:0] s_sel,
  input  logic          s_ack,
  input  logic          s_stall,
  input  logic [DW-1:0] s_dat_r
);
  grant_t                   grant;
  logic [NUM_M-1:0]         ack_v, stall_v;
  logic [NUM_M-1:0][DW-1:0] rdat_v;

  arb_grant_core u_core (
    .clk   (clk),
    .rst   (rst),
    .req   ({m1_cyc, m0_cyc}),
    .grant (grant)
  );

  arb_req_mux #(.AW(AW), .DW(DW), .SW(SW)) u_mux (
    .grant   (grant),
    .cyc     ({m1_cyc, m0_cyc}),
    .stb     ({m1_stb, m0_stb}),
    .we      ({m1_we, m0_we}),
    .adr     ({m1_adr, m0_adr}),
    .dat_w   ({m1_dat_w, m0_dat_w}),
    .sel     ({m1_sel, m0_sel}),
    .o_cyc   (s_cyc),
    .o_stb   (s_stb),
    .o_we    (s_we),
    .o_adr   (s_adr),
    .o_dat_w (s_dat_w),
    .o_sel   (s_sel)
  );

  arb_resp_route #(.DW(DW)) u_route (
    .grant   (grant),
    .i_ack   (s_ack),
    .i_stall (s_stall),
    .i_dat_r (s_dat_r),
    .ack     (ack_v),
    .stall   (stall_v),
    .dat_r   (rdat_v)
  );

  assign m0_ack   = ack_v[0];
  assign m1_ack   = ack_v[1];
  assign m0_stall = stall_v[0];
  assign m1_stall = stall_v[1];
  assign m0_dat_r = rdat_v[0];
  assign m1_dat_r = rdat_v[1];

  AST_SINGLE_READY: assert property (@(posedge clk) disable iff (rst)
    (m0_stall || m1_stall) && !(m0_ack && m1_ack)); // R5
  AST_STB_FROM_OWNER: assert property (@(posedge clk) disable iff (rst)
    s_stb |-> ((m0_stb && m0_cyc && !m0_stall == !s_stall && grant.id == 1'b0) ||
               (m1_stb && m1_cyc && grant.id == 1'b1))); // R6
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !grant.valid |-> (!s_cyc && !s_stb && m0_stall && m1_stall)); // R6
endmodule

// File: tb/test_cyc_hold_arbiter.sv
`timescale 1ns/100ps
module test_cyc_hold_arbiter;
  localparam int AW = 32;
  localparam int DW = 32;
  localparam int SW = DW / 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic          cyc [2], stb [2], we [2];
  logic [AW-1:0] adr [2];
  logic [DW-1:0] dw  [2];
  logic [SW-1:0] sel [2];
  logic          ack [2], stall [2];
  logic [DW-1:0] dr  [2];
  logic          s_cyc, s_stb, s_we, s_ack, s_stall;
  logic [AW-1:0] s_adr;
  logic [DW-1:0] s_dat_w, s_dat_r;
  logic [SW-1:0] s_sel;

  cyc_hold_arbiter #(.AW(AW), .DW(DW)) i_cyc_hold_arbiter (
    .clk(clk), .rst(rst),
    .m0_cyc(cyc[0]), .m0_stb(stb[0]), .m0_we(we[0]), .m0_adr(adr[0]),
    .m0_dat_w(dw[0]), .m0_sel(sel[0]), .m0_ack(ack[0]), .m0_stall(stall[0]), .m0_dat_r(dr[0]),
    .m1_cyc(cyc[1]), .m1_stb(stb[1]), .m1_we(we[1]), .m1_adr(adr[1]),
    .m1_dat_w(dw[1]), .m1_sel(sel[1]), .m1_ack(ack[1]), .m1_stall(stall[1]), .m1_dat_r(dr[1]),
    .s_cyc(s_cyc), .s_stb(s_stb), .s_we(s_we), .s_adr(s_adr), .s_dat_w(s_dat_w),
    .s_sel(s_sel), .s_ack(s_ack), .s_stall(s_stall), .s_dat_r(s_dat_r)
  );

  int   n_chk = 0, n_err = 0;
  bit   done  = 1'b0;
  logic own_v = 1'b0, own = 1'b0, last = 1'b1;
  logic [31:0] lf = 32'h1ACE_B00C;

  task automatic chk(bit ok, string tag, logic [127:0] act, logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // one clock: compare outputs mid-cycle, then advance the model at the edge
  task automatic step(string tag);
    logic [127:0] fe, fa, re, ra;
    @(negedge clk);
    fe = '0;
    if (own_v && !rst)
      fe = {cyc[own], cyc[own] & stb[own], we[own], adr[own], dw[own], sel[own]};
    fa = {s_cyc, s_stb, s_we, s_adr, s_dat_w, s_sel};
    chk(fa == fe, {tag, " R6 downstream"}, fa, fe);
    for (int i = 0; i < 2; i++) begin
      bit o = own_v && !rst && own == 1'(i);
      re = o ? {s_ack, s_stall, s_dat_r} : {1'b0, 1'b1, {DW{1'b0}}};
      ra = {ack[i], stall[i], dr[i]};
      chk(ra == re, {tag, o ? " R7 owner resp" : " R5 blocked resp"}, ra, re);
    end
    @(posedge clk);
    if (rst) begin
      own_v = 1'b0; own = 1'b0; last = 1'b1;
    end else if (!(own_v && cyc[own])) begin
      if (cyc[0] && cyc[1]) begin own_v = 1'b1; own = ~last; last = own; end
      else if (cyc[0])      begin own_v = 1'b1; own = 1'b0;  last = 1'b0; end
      else if (cyc[1])      begin own_v = 1'b1; own = 1'b1;  last = 1'b1; end
      else                  own_v = 1'b0;
    end
    #1;
  endtask

  function automatic logic [31:0] nx(logic [31:0] v);
    return {v[30:0], v[31] ^ v[21] ^ v[1] ^ v[0]};
  endfunction

  task automatic fill();
    for (int i = 0; i < 2; i++) begin
      lf = nx(lf); adr[i] = lf; lf = nx(lf); dw[i] = lf;
      sel[i] = lf[7:4]; we[i] = lf[9]; stb[i] = lf[11];
    end
    lf = nx(lf); s_dat_r = lf; s_ack = lf[3]; s_stall = lf[6];
  endtask

  task automatic setc(logic c0, logic c1);
    cyc[0] = c0; cyc[1] = c1;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    setc(1, 1); fill();
    #1;
    step("R8 reset"); step("R8 reset");
    rst = 1'b0;
    // both raise together: first tie goes to master 0
    step("R2 tie1 wait"); fill();
    step("R2 tie1 m0");   fill();
    step("R3 hold");      fill();
    step("R3 hold");      fill();
    setc(0, 1);
    step("R4 release");   fill();
    step("R4 m1 owns");   fill();
    setc(0, 0);
    step("R4 m1 drop");   fill();
    step("R8 idle");      fill();
    setc(1, 1);
    step("R2 tie2 wait"); fill();
    step("R2 tie2 m0");   fill();
    setc(0, 0);
    step("R2 drop");
    setc(1, 1);
    step("R2 tie3 wait"); fill();
    step("R2 tie3 m1");   fill();
    setc(1, 0);
    step("R4 m1 drop");   fill();
    step("R1 m0 owns");   fill();
    setc(0, 0);
    step("R1 idle");
    setc(0, 1);
    step("R1 m1 wait");   fill();
    step("R1 m1 owns");   fill();
    // one-clock release with other master waiting
    setc(1, 1);
    step("R3 m1 hold");
    setc(1, 0);
    step("R4 pulse");
    setc(1, 1);
    step("R4 m0 owns");   fill();
    // pseudo-random sweep over all inputs
    for (int k = 0; k < 3000; k++) begin
      fill();
      lf = nx(lf);
      if (lf[1:0] == 2'b00) cyc[0] = ~cyc[0];
      if (lf[5:4] == 2'b00) cyc[1] = ~cyc[1];
      step("R1/R3/R4 sweep");
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule